// File: doc/BRIEF.md
# Multiplexed Address/Data Register Port

This block is a slave control port. It gives access to a bank of 8-bit configuration registers and one status register over a single 10-bit bidirectional bus. The bus is modelled as three signals: `ad_i` for input, `ad_o` for output and `ad_oe_o` for output enable. An active-low select starts an access and a read/not-write input sets its direction. Every access takes two rising edges of the access clock. The first edge is the address phase and the second is the data phase. The two upper bus bits carry a tag that marks each write word as an address or as data.

On a read, the port takes over the bus right after the address edge. It presents the selected register, and the next edge hands the bus back. On a write, the addressed register takes the low byte of the tagged data word. The five status bits come from outside the block and are read only. The writable registers also appear in parallel on `cfg_o` for the logic they configure.

Top module: `ad_reg_port`

## Requirements
- R1: After reset, `ad_oe_o` is low, the port waits for an address phase, and every writable register is 00h.
- R2: While `sel_ni` is high, no access is started. The port neither drives the bus nor changes any register.
- R3: With `sel_ni` low and `rnw_i` low, an address word tagged 00b in `ad_i[9:8]` is followed by a data word tagged 11b. The next edge loads `ad_i[7:0]` of the data word into the register at the captured 8-bit address, and `cfg_o` shows the new value after that edge.
- R4: A write address word whose tag is not 00b is discarded. The port stays in the address phase, so the word that follows is treated as a new address word.
- R5: A write data word whose tag is not 11b is discarded. All registers keep their values and the port returns to the address phase.
- R6: On a read (`rnw_i` high at the address edge), from that edge until the next one the port drives `ad_oe_o` high and `ad_o` = {00b, register byte}. The value is captured at the address edge and held stable. After the next edge `ad_oe_o` is low again.
- R7: Reading a register does not change its contents.
- R8: Address 01h reads the five external status flags in bits [4:0], with bits [7:5] zero. It cannot be written.
- R9: The writable registers occupy addresses 02h to 0Fh, and `cfg_o[8*(a-2) +: 8]` holds register a. Every other address reads as zero and ignores writes.
- R10: Writing 27h to address 0Dh stores 27h there. Reading it back returns 27h and it appears on its `cfg_o` slice.
- R11: If `sel_ni` rises during the data phase of a read, `ad_oe_o` drops in the same cycle. If it rises before the data edge of a write, no register is written. In both cases the port returns to the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Access clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Control-access select, active low |
| rnw_i | input | 1 | 1 = read, 0 = write, sampled at the address edge |
| ad_i | input | 10 | Bus input: [9:8] tag, [7:0] address or data |
| ad_o | output | 10 | Bus output during read data |
| ad_oe_o | output | 1 | Bus output enable |
| status_i | input | 5 | External read-only status flags |
| cfg_o | output | 112 | Writable registers 02h..0Fh, low address in the low byte |

## Verification
The hardest states to reach are the mis-tagged and aborted phases. A wrong address tag must leave the port in the address phase, so that a following 11b-tagged word is not taken as data. A select that rises between the two edges must cancel the access. The stimulus reaches these by mixing random legal accesses with random operations that corrupt either tag or lift the select in mid-access. After each operation it checks the whole `cfg_o` vector against a model. During every read it also changes the status flags and `ad_i` to show that the driven value holds.

// File: rtl/ad_port_pkg.sv
package ad_port_pkg;
  typedef enum logic [1:0] {
    PH_ADDR   = 2'd0,
    PH_WDATA  = 2'd1,
    PH_RDRIVE = 2'd2
  } port_phase_e;

  localparam logic [1:0] TAG_WADDR = 2'b00;
  localparam logic [1:0] TAG_WDATA = 2'b11;
endpackage

// File: rtl/ad_phase_ctl.sv
module ad_phase_ctl
  import ad_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_ni,
  input  logic       rnw_i,
  input  logic [1:0] tag_i,
  output logic       ld_addr_o,
  output logic       ld_read_o,
  output logic       we_o,
  output logic       drive_o
);
  port_phase_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    ld_addr_o = 1'b0;
    ld_read_o = 1'b0;
    we_o      = 1'b0;
    unique case (state_q)
      PH_ADDR: begin
        if (!sel_ni) begin
          if (rnw_i) begin
            ld_addr_o = 1'b1;
            ld_read_o = 1'b1;
            state_d   = PH_RDRIVE;
          end else if (tag_i == TAG_WADDR) begin
            ld_addr_o = 1'b1;
            state_d   = PH_WDATA;
          end
        end
      end
      PH_WDATA: begin
        state_d = PH_ADDR;
        we_o    = !sel_ni && (tag_i == TAG_WDATA);
      end
      PH_RDRIVE: state_d = PH_ADDR;
      default:   state_d = PH_ADDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PH_ADDR;
    else         state_q <= state_d;
  end

  // deselect releases the bus without waiting for an edge
  assign drive_o = (state_q == PH_RDRIVE) && !sel_ni;

  a_r6_single_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |=> !drive_o);
  a_r4_we_after_tagged_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> $past(!sel_ni && !rnw_i && tag_i == TAG_WADDR));
  a_r2_idle_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_ADDR && sel_ni) |=> state_q == PH_ADDR);
  a_r11_no_write_on_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_WDATA && sel_ni) |-> !we_o);
endmodule

// File: rtl/ad_reg_bank.sv
module ad_reg_bank #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int WR_BASE   = 2,
  parameter int WR_COUNT  = 14,
  parameter int STAT_ADDR = 1,
  parameter int STAT_W    = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [1:0]             tag_i,
  input  logic [AW-1:0]          raddr_i,
  input  logic [STAT_W-1:0]      status_i,
  output logic [DW-1:0]          rdata_o,
  output logic [WR_COUNT*DW-1:0] cfg_o
);
  logic [WR_COUNT-1:0][DW-1:0] regs_q;
  logic [WR_COUNT-1:0]         hit_w;
  logic [WR_COUNT-1:0]         hit_r;

  for (genvar g = 0; g < WR_COUNT; g++) begin : g_dec
    localparam logic [AW-1:0] RegAddr = AW'(WR_BASE + g);
    assign hit_w[g] = we_i && (waddr_i == RegAddr);
    assign hit_r[g] = (raddr_i == RegAddr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else begin
      for (int i = 0; i < WR_COUNT; i++)
        if (hit_w[i]) regs_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (raddr_i == AW'(STAT_ADDR)) rdata_o = DW'(status_i);
    for (int i = 0; i < WR_COUNT; i++)
      if (hit_r[i]) rdata_o = regs_q[i];
  end

  assign cfg_o = regs_q;

  a_r5_we_needs_data_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> tag_i == 2'b11);
  a_r7_hold_without_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q));
endmodule

// File: rtl/ad_reg_port.sv
module ad_reg_port #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int WR_BASE   = 2,
  parameter int WR_COUNT  = 14,
  parameter int STAT_ADDR = 1,
  parameter int STAT_W    = 5,
  localparam int BW       = AW + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sel_ni,
  input  logic                   rnw_i,
  input  logic [BW-1:0]          ad_i,
  output logic [BW-1:0]          ad_o,
  output logic                   ad_oe_o,
  input  logic [STAT_W-1:0]      status_i,
  output logic [WR_COUNT*DW-1:0] cfg_o
);
  logic          ld_addr, ld_read, we, drive;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rd_q, rdata;

  ad_phase_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_ni    (sel_ni),
    .rnw_i     (rnw_i),
    .tag_i     (ad_i[BW-1:BW-2]),
    .ld_addr_o (ld_addr),
    .ld_read_o (ld_read),
    .we_o      (we),
    .drive_o   (drive)
  );

  ad_reg_bank #(
    .AW(AW), .DW(DW), .WR_BASE(WR_BASE), .WR_COUNT(WR_COUNT),
    .STAT_ADDR(STAT_ADDR), .STAT_W(STAT_W)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .waddr_i  (addr_q),
    .wdata_i  (ad_i[DW-1:0]),
    .tag_i    (ad_i[BW-1:BW-2]),
    .raddr_i  (ad_i[AW-1:0]),
    .status_i (status_i),
    .rdata_o  (rdata),
    .cfg_o    (cfg_o)
  );

  // read value frozen at the address edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rd_q   <= '0;
    end else begin
      if (ld_addr) addr_q <= ad_i[AW-1:0];
      if (ld_read) rd_q   <= rdata;
    end
  end

  assign ad_oe_o = drive;
  assign ad_o    = drive ? {2'b00, rd_q} : '0;

  a_r6_read_follows_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ad_oe_o) |-> $past(!sel_ni && rnw_i));
  a_r11_release_on_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |-> !ad_oe_o);
endmodule

// File: tb/ad_reg_port_bench.sv
module ad_reg_port_bench;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sel_ni = 1'b1;
  logic         rnw_i = 1'b0;
  logic [9:0]   ad_i = '0;
  logic [9:0]   ad_o;
  logic         ad_oe_o;
  logic [4:0]   status_i = '0;
  logic [111:0] cfg_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] model [14];

  always #4 clk = ~clk;

  ad_reg_port u_ad_reg_port (
    .clk_i(clk), .rst_ni(rst_ni), .sel_ni(sel_ni), .rnw_i(rnw_i),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .status_i(status_i), .cfg_o(cfg_o)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [7:0] a);
    if (a == 8'h01) return {3'b000, status_i};
    if (a >= 8'h02 && a <= 8'h0F) return model[a - 8'h02];
    return 8'h00;
  endfunction

  function automatic logic [111:0] exp_cfg();
    logic [111:0] v;
    for (int i = 0; i < 14; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic idle();
    @(negedge clk);
    sel_ni = 1'b1;
    ad_i   = 10'($urandom);
  endtask

  // write with chosen tags; data edge only loads when both tags are right
  task automatic do_write(logic [7:0] a, logic [7:0] d, logic [1:0] ta, logic [1:0] td,
                          string req);
    @(negedge clk);
    sel_ni = 1'b0; rnw_i = 1'b0; ad_i = {ta, a};
    @(negedge clk);
    ad_i = {td, d};
    @(negedge clk);
    sel_ni = 1'b1;
    if (ta == 2'b00 && td == 2'b11 && a >= 8'h02 && a <= 8'h0F) model[a - 8'h02] = d;
    chk(req, cfg_o, exp_cfg());
  endtask

  task automatic do_read(logic [7:0] a, string req);
    logic [7:0] e;
    @(negedge clk);
    sel_ni = 1'b0; rnw_i = 1'b1; ad_i = {2'($urandom), a};
    e = exp_read(a);
    @(negedge clk);
    chk(req, {ad_oe_o, ad_o}, {1'b1, 2'b00, e});
    status_i = 5'($urandom);
    ad_i     = 10'($urandom);
    #2;
    chk({req, " R6 stable"}, {ad_oe_o, ad_o}, {1'b1, 2'b00, e});
    @(negedge clk);
    chk("R6 release", ad_oe_o, 1'b0);
    sel_ni = 1'b1;
  endtask

  task automatic abort_read(logic [7:0] a);
    @(negedge clk);
    sel_ni = 1'b0; rnw_i = 1'b1; ad_i = {2'b00, a};
    @(negedge clk);
    sel_ni = 1'b1;
    #1;
    chk("R11 read abort", ad_oe_o, 1'b0);
    @(negedge clk);
    chk("R11 read abort idle", ad_oe_o, 1'b0);
  endtask

  task automatic abort_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    sel_ni = 1'b0; rnw_i = 1'b0; ad_i = {2'b00, a};
    @(negedge clk);
    sel_ni = 1'b1; ad_i = {2'b11, d};
    @(negedge clk);
    chk("R11 write abort", cfg_o, exp_cfg());
  endtask

  task automatic deselected();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      sel_ni = 1'b1; rnw_i = 1'($urandom); ad_i = {k == 0 ? 2'b00 : 2'b11, 8'($urandom)};
      #1;
      chk("R2 no drive", ad_oe_o, 1'b0);
    end
    @(negedge clk);
    chk("R2 no write", cfg_o, exp_cfg());
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 14; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 oe", ad_oe_o, 1'b0);
    chk("R1 cfg", cfg_o, 112'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 oe after release", ad_oe_o, 1'b0);
    do_read(8'h05, "R1 read default");

    status_i = 5'h15;
    do_read(8'h01, "R8 status");
    do_write(8'h01, 8'hFF, 2'b00, 2'b11, "R8 status not writable");
    status_i = 5'h0A;
    do_read(8'h01, "R8 status after write");

    do_write(8'h0D, 8'h27, 2'b00, 2'b11, "R10 cfg slice");
    do_read(8'h0D, "R10 readback");
    do_read(8'h0D, "R7 second read");

    do_write(8'h02, 8'hA5, 2'b00, 2'b11, "R3 low reg");
    do_write(8'h0F, 8'h5A, 2'b00, 2'b11, "R3 high reg");
    do_read(8'h02, "R3 read low");
    do_read(8'h0F, "R3 read high");

    do_write(8'h40, 8'h33, 2'b00, 2'b11, "R9 unimpl write");
    do_read(8'h40, "R9 unimpl read");
    do_read(8'h00, "R9 addr 00");
    do_read(8'h10, "R9 addr 10");

    do_write(8'h03, 8'h77, 2'b01, 2'b11, "R4 bad addr tag");
    do_write(8'h03, 8'h77, 2'b11, 2'b11, "R4 tag 11 as addr");
    do_write(8'h0D, 8'h99, 2'b00, 2'b10, "R5 bad data tag");
    do_read(8'h0D, "R5 value kept");
    abort_read(8'h0D);
    abort_write(8'h0D, 8'h11);
    do_read(8'h0D, "R11 value kept");
    deselected();

    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      int op;
      a  = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 16);
      op = $urandom % 8;
      status_i = 5'($urandom);
      case (op)
        0, 1:    do_write(a, 8'($urandom), 2'b00, 2'b11, "R3 random write");
        2:       do_write(a, 8'($urandom), 2'($urandom % 3) + 2'd1, 2'b11, "R4 random bad addr tag");
        3:       do_write(a, 8'($urandom), 2'b00, 2'($urandom % 3), "R5 random bad data tag");
        4, 5:    do_read(a, "R6 random read");
        6:       if ($urandom % 2 == 0) abort_read(a); else abort_write(a, 8'($urandom));
        default: deselected();
      endcase
      if ($urandom % 4 == 0) idle();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule